// File: doc/BRIEF.md
# Line Result Buffer Assembler

This block sits behind a video-line data slicer and turns its per-line decisions into one field's worth of results. For every selected line that the front end has examined, it receives a capture: which of the five result slots the line belongs to, whether valid data was found, whether that data came at single or double rate, and the received bits. It formats each capture into a 32-bit slot word and keeps a 16-bit status word that summarises presence, rate and field parity for the whole field.

Captures arrive on a valid/ready stream. The block takes a capture on any clock edge where `cap_valid` and `cap_ready` are both high. `cap_ready` is high on every cycle except the cycle that carries the line-10 strobe. That cycle clears the field, so a capture offered then is not taken. The source must hold the capture and offer it again on a later cycle. The line-10 strobe clears all slot words and status bits and stores the field parity. The line-26 strobe raises `field_done`, which tells the reader that the field's results are stable. The results can be read in parallel from `buf_flat` and `status_word` until the next line-10 strobe.

Top module: `line_result_assembler`

## Requirements
- R1: One clock after a line-10 strobe, every slot word is zero, status bits 0-6 and 8-15 are zero, and `field_done` is low.
- R2: One clock after a line-10 strobe, status bit 7 equals the `field_odd` value sampled with that strobe (1 = odd field, 0 = even field). The bit keeps that value until the next line-10 strobe.
- R3: A found capture with `cap_wide`=0 (single rate) gives a slot word with bits 0-14 at 0 and bit 15 at 1. Bits 16-31 equal `cap_bits[15:0]`, so received bit k lands in word bit 16+k.
- R4: A found capture with `cap_wide`=1 (double rate) gives a slot word equal to `cap_bits`, so the first received byte sits in bits 0-7.
- R5: A capture with `cap_found`=0 makes that slot word all zeros and clears both of that slot's status bits.
- R6: After a capture to slot s (0-4), status bit s equals `cap_found`, and status bit 8+s equals `cap_found` AND `cap_wide`. A rate bit is never 1 while its presence bit is 0.
- R7: Status bits 5, 6, 13 and 14 always read 0.
- R8: One clock after a line-26 strobe, `field_done` is 1 unless a line-10 strobe came in the same cycle. It stays 1 until the next line-10 strobe.
- R9: A capture whose `cap_slot` is 5, 6 or 7 is accepted but changes no slot word and no status bit.
- R10: A second capture to the same slot within one field fully replaces the first, including its status bits.
- R11: `cap_ready` is low in exactly the cycles where `line10_strobe` is high. A capture offered in such a cycle is not written.
- R12: After reset, all slot words and the status word are zero, `field_done` is low and `cap_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_valid | input | 1 | Capture offered on the stream |
| cap_ready | output | 1 | Block can take a capture this cycle |
| cap_slot | input | 3 | Slot index; 0-4 are valid, higher values are ignored |
| cap_found | input | 1 | Valid data was found on the line |
| cap_wide | input | 1 | 1 = double-rate line, 0 = single-rate line |
| cap_bits | input | 32 | Received bits, first received in bit 0 |
| line10_strobe | input | 1 | One-cycle pulse at the start of a field's window |
| line26_strobe | input | 1 | One-cycle pulse when the field's captures are complete |
| field_odd | input | 1 | Field parity, sampled with the line-10 strobe |
| buf_flat | output | 160 | Slot words; slot s occupies bits 32s+31 down to 32s |
| status_word | output | 16 | Presence, parity and rate summary |
| field_done | output | 1 | Results are stable for reading |

## Verification
Single-rate and double-rate captures are driven with asymmetric bit patterns. A padding error, a swapped half or a copy of the raw bits therefore gives a visibly different slot word. A found capture followed by a not-found capture to the same slot tests whether old content and flags really go away. A double-rate capture followed by a single-rate capture tests whether the rate bit is cleared, not just set. Out-of-range slot indices, a capture offered during the line-10 cycle, and both field parities each test a path that a correct write would otherwise hide.

// File: rtl/lrb_pkg.sv
package lrb_pkg;
  typedef enum logic {
    RATE_1X = 1'b0,
    RATE_2X = 1'b1
  } rate_e;

  typedef struct packed {
    logic  found;
    rate_e rate;
  } slot_flags_t;
endpackage

// File: rtl/lrb_formatter.sv
module lrb_formatter
  import lrb_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              found,
  input  rate_e             rate,
  input  logic [WORD_W-1:0] raw,
  output logic [WORD_W-1:0] word
);
  localparam int HALF = WORD_W / 2;

  // single rate: payload in upper half, marker bit just below it
  logic [WORD_W-1:0] narrow_word;
  assign narrow_word = {raw[HALF-1:0], 1'b1, {(HALF-1){1'b0}}};

  always_comb begin
    if (!found)
      word = '0;
    else if (rate == RATE_2X)
      word = raw;
    else
      word = narrow_word;
  end
endmodule

// File: rtl/lrb_slot_bank.sv
module lrb_slot_bank #(
  parameter int NSLOT   = 5,
  parameter int WORD_W  = 32,
  parameter int SLOT_IW = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    wr_en,
  input  logic [SLOT_IW-1:0]      wr_slot,
  input  logic [WORD_W-1:0]       wr_word,
  output logic [NSLOT*WORD_W-1:0] bank_flat
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic [WORD_W-1:0] word_q;
    logic              hit;
    assign hit = wr_en && (wr_slot == SLOT_IW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= '0;
      else if (clr)
        word_q <= '0;
      else if (hit)
        word_q <= wr_word;
    end

    assign bank_flat[i*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/lrb_status.sv
module lrb_status
  import lrb_pkg::*;
#(
  parameter int NSLOT      = 5,
  parameter int STAT_W     = 16,
  parameter int SLOT_IW    = 3,
  parameter int RATE_OFS   = 8,
  parameter int PARITY_BIT = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               field_odd,
  input  logic               wr_en,
  input  logic [SLOT_IW-1:0] wr_slot,
  input  slot_flags_t        wr_flags,
  output logic [STAT_W-1:0]  status_word
);
  logic [NSLOT-1:0] present_q;
  logic [NSLOT-1:0] wide_q;
  logic             odd_q;

  for (genvar i = 0; i < NSLOT; i++) begin : g_flag
    logic hit;
    assign hit = wr_en && (wr_slot == SLOT_IW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        present_q[i] <= 1'b0;
        wide_q[i]    <= 1'b0;
      end else if (clr) begin
        present_q[i] <= 1'b0;
        wide_q[i]    <= 1'b0;
      end else if (hit) begin
        present_q[i] <= wr_flags.found;
        wide_q[i]    <= wr_flags.found && (wr_flags.rate == RATE_2X);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      odd_q <= 1'b0;
    else if (clr)
      odd_q <= field_odd;
  end

  always_comb begin
    status_word = '0;
    for (int i = 0; i < NSLOT; i++) begin
      status_word[i]          = present_q[i];
      status_word[RATE_OFS+i] = wide_q[i];
    end
    status_word[PARITY_BIT] = odd_q;
  end
endmodule

// File: rtl/line_result_assembler.sv
module line_result_assembler
  import lrb_pkg::*;
#(
  parameter int NSLOT      = 5,
  parameter int WORD_W     = 32,
  parameter int STAT_W     = 16,
  parameter int RATE_OFS   = 8,
  parameter int PARITY_BIT = 7,
  parameter int SLOT_IW    = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_valid,
  output logic                    cap_ready,
  input  logic [SLOT_IW-1:0]      cap_slot,
  input  logic                    cap_found,
  input  logic                    cap_wide,
  input  logic [WORD_W-1:0]       cap_bits,
  input  logic                    line10_strobe,
  input  logic                    line26_strobe,
  input  logic                    field_odd,
  output logic [NSLOT*WORD_W-1:0] buf_flat,
  output logic [STAT_W-1:0]       status_word,
  output logic                    field_done
);
  localparam logic [SLOT_IW-1:0] LAST_SLOT = SLOT_IW'(NSLOT - 1);

  slot_flags_t       flags;
  logic              take;
  logic              in_range;
  logic [WORD_W-1:0] fmt_word;

  assign cap_ready   = !line10_strobe;
  assign in_range    = (cap_slot <= LAST_SLOT);
  assign take        = cap_valid && cap_ready && in_range;
  assign flags.found = cap_found;
  assign flags.rate  = cap_wide ? RATE_2X : RATE_1X;

  lrb_formatter #(.WORD_W(WORD_W)) u_fmt (
    .found (cap_found),
    .rate  (flags.rate),
    .raw   (cap_bits),
    .word  (fmt_word)
  );

  lrb_slot_bank #(.NSLOT(NSLOT), .WORD_W(WORD_W), .SLOT_IW(SLOT_IW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (line10_strobe),
    .wr_en     (take),
    .wr_slot   (cap_slot),
    .wr_word   (fmt_word),
    .bank_flat (buf_flat)
  );

  lrb_status #(
    .NSLOT(NSLOT), .STAT_W(STAT_W), .SLOT_IW(SLOT_IW),
    .RATE_OFS(RATE_OFS), .PARITY_BIT(PARITY_BIT)
  ) u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (line10_strobe),
    .field_odd   (field_odd),
    .wr_en       (take),
    .wr_slot     (cap_slot),
    .wr_flags    (flags),
    .status_word (status_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      field_done <= 1'b0;
    else if (line10_strobe)
      field_done <= 1'b0;
    else if (line26_strobe)
      field_done <= 1'b1;
  end
endmodule

// File: rtl/lrb_checker.sv
module lrb_checker #(
  parameter int NSLOT      = 5,
  parameter int WORD_W     = 32,
  parameter int STAT_W     = 16,
  parameter int RATE_OFS   = 8,
  parameter int PARITY_BIT = 7,
  parameter int SLOT_IW    = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cap_valid,
  input logic                    cap_ready,
  input logic [SLOT_IW-1:0]      cap_slot,
  input logic                    cap_found,
  input logic                    cap_wide,
  input logic [WORD_W-1:0]       cap_bits,
  input logic                    line10_strobe,
  input logic                    line26_strobe,
  input logic                    field_odd,
  input logic [NSLOT*WORD_W-1:0] buf_flat,
  input logic [STAT_W-1:0]       status_word,
  input logic                    field_done
);
  localparam int HALF = WORD_W / 2;

  logic              acc_q;
  logic [SLOT_IW-1:0] slot_q;
  logic [WORD_W-1:0] exp_q;
  logic [WORD_W-1:0] sel_word;
  logic              oor;

  assign oor = cap_slot >= SLOT_IW'(NSLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= 1'b0;
      slot_q <= '0;
      exp_q  <= '0;
    end else begin
      acc_q  <= cap_valid && !line10_strobe && !oor;
      slot_q <= cap_slot;
      if (!cap_found)
        exp_q <= '0;
      else if (cap_wide)
        exp_q <= cap_bits;
      else
        exp_q <= {cap_bits[HALF-1:0], 1'b1, {(HALF-1){1'b0}}};
    end
  end

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < NSLOT; i++)
      if (slot_q == SLOT_IW'(i)) sel_word = buf_flat[i*WORD_W +: WORD_W];
  end

  a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    line10_strobe |=> (buf_flat == '0) && (status_word[6:0] == '0) &&
                      (status_word[15:8] == '0) && !field_done);

  a_r2_parity: assert property (@(posedge clk) disable iff (!rst_n)
    line10_strobe |=> status_word[PARITY_BIT] == $past(field_odd));

  a_r3_slot_content: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |-> sel_word == exp_q);

  a_r6_rate_implies_present: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[RATE_OFS +: NSLOT] & ~status_word[NSLOT-1:0]) == '0);

  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[6:5] == 2'b00 && status_word[14:13] == 2'b00);

  a_r8_done: assert property (@(posedge clk) disable iff (!rst_n)
    line26_strobe && !line10_strobe |=> field_done);

  a_r9_ignore_range: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid && oor && !line10_strobe |=> $stable(buf_flat) && $stable(status_word));

  a_r11_ready: assert property (@(posedge clk) disable iff (!rst_n)
    line10_strobe |-> !cap_ready);
endmodule

bind line_result_assembler lrb_checker #(
  .NSLOT(NSLOT), .WORD_W(WORD_W), .STAT_W(STAT_W),
  .RATE_OFS(RATE_OFS), .PARITY_BIT(PARITY_BIT), .SLOT_IW(SLOT_IW)
) u_chk (.*);

// File: tb/sim_line_result_assembler.sv
module sim_line_result_assembler;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cap_valid = 1'b0;
  logic         cap_ready;
  logic [2:0]   cap_slot = '0;
  logic         cap_found = 1'b0;
  logic         cap_wide = 1'b0;
  logic [31:0]  cap_bits = '0;
  logic         line10_strobe = 1'b0;
  logic         line26_strobe = 1'b0;
  logic         field_odd = 1'b0;
  logic [159:0] buf_flat;
  logic [15:0]  status_word;
  logic         field_done;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  logic [31:0] exp_b [5];
  logic [15:0] exp_st;

  always #2.5 clk = ~clk;

  line_result_assembler u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 5; i++) check(req, buf_flat[i*32 +: 32], exp_b[i]);
    check(req, {16'h0, status_word}, {16'h0, exp_st});
  endtask

  function automatic logic [31:0] fmt(input logic f, input logic w, input logic [31:0] b);
    if (!f) return 32'h0;
    if (w) return b;
    return {b[15:0], 1'b1, 15'h0};
  endfunction

  // drive at negedge, capture at posedge, leave at following negedge
  task automatic capture(input logic [2:0] s, input logic f, input logic w, input logic [31:0] b);
    @(negedge clk);
    cap_valid = 1'b1; cap_slot = s; cap_found = f; cap_wide = w; cap_bits = b;
    @(negedge clk);
    cap_valid = 1'b0;
    if (s < 5) begin
      exp_b[s] = fmt(f, w, b);
      exp_st[s] = f;
      exp_st[8+s] = f & w;
    end
  endtask

  task automatic t_reset;
    check("R12 buffers", {31'h0, |buf_flat}, 32'h0);
    check("R12 status", {16'h0, status_word}, 32'h0);
    check("R12 done", {31'h0, field_done}, 32'h0);
    check("R12 ready", {31'h0, cap_ready}, 32'h1);
  endtask

  task automatic t_field_start(input logic odd);
    @(negedge clk);
    line10_strobe = 1'b1; field_odd = odd;
    #1 check("R11 ready low on clear", {31'h0, cap_ready}, 32'h0);
    @(negedge clk);
    line10_strobe = 1'b0;
    for (int i = 0; i < 5; i++) exp_b[i] = '0;
    exp_st = {8'h0, odd, 7'h0};
    check_all("R1 R2 clear and parity");
    check("R1 done low", {31'h0, field_done}, 32'h0);
  endtask

  task automatic t_narrow;
    capture(3'd0, 1'b1, 1'b0, 32'hFFFF_A5C3);
    check("R3 single-rate pad", buf_flat[31:0], 32'hA5C3_8000);
    check_all("R6 single-rate status");
  endtask

  task automatic t_wide;
    capture(3'd1, 1'b1, 1'b1, 32'hDEAD_BEEF);
    check("R4 double-rate word", buf_flat[63:32], 32'hDEAD_BEEF);
    check("R6 rate bit", {31'h0, status_word[9]}, 32'h1);
    check_all("R6 double-rate status");
  endtask

  task automatic t_not_found;
    capture(3'd2, 1'b1, 1'b1, 32'h1234_5678);
    capture(3'd2, 1'b0, 1'b1, 32'hFFFF_FFFF);
    check("R5 empty slot", buf_flat[95:64], 32'h0);
    check("R5 flags", {30'h0, status_word[10], status_word[2]}, 32'h0);
    check_all("R5 not found");
  endtask

  task automatic t_overwrite;
    capture(3'd4, 1'b1, 1'b1, 32'hCAFE_F00D);
    capture(3'd4, 1'b1, 1'b0, 32'h0000_0F0F);
    check("R10 replaced word", buf_flat[159:128], 32'h0F0F_8000);
    check("R10 rate cleared", {31'h0, status_word[12]}, 32'h0);
    check_all("R10 overwrite");
  endtask

  task automatic t_out_of_range;
    capture(3'd5, 1'b1, 1'b1, 32'h5555_AAAA);
    check_all("R9 slot 5 ignored");
    capture(3'd7, 1'b1, 1'b0, 32'h0000_FFFF);
    check_all("R9 slot 7 ignored");
  endtask

  task automatic t_reserved;
    capture(3'd3, 1'b1, 1'b1, 32'h0102_0304);
    check("R7 reserved bits", {28'h0, status_word[14:13], status_word[6:5]}, 32'h0);
    check_all("R7 full status");
  endtask

  task automatic t_done;
    @(negedge clk); line26_strobe = 1'b1;
    @(negedge clk); line26_strobe = 1'b0;
    check("R8 done raised", {31'h0, field_done}, 32'h1);
    @(negedge clk);
    check("R8 done held", {31'h0, field_done}, 32'h1);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    line10_strobe = 1'b1; field_odd = 1'b1;
    cap_valid = 1'b1; cap_slot = 3'd0; cap_found = 1'b1; cap_wide = 1'b1; cap_bits = 32'h8765_4321;
    #1 check("R11 ready low", {31'h0, cap_ready}, 32'h0);
    @(negedge clk);
    line10_strobe = 1'b0; cap_valid = 1'b0;
    for (int i = 0; i < 5; i++) exp_b[i] = '0;
    exp_st = 16'h0080;
    check_all("R11 capture refused");
    check("R8 done cleared", {31'h0, field_done}, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 5; i++) exp_b[i] = '0;
    exp_st = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_field_start(1'b1);
    t_narrow;
    t_wide;
    t_not_found;
    t_overwrite;
    t_out_of_range;
    t_reserved;
    t_done;
    t_field_start(1'b0);
    t_done;
    t_backpressure;
    ended = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule